// File: doc/BRIEF.md
# Dual 8-bit Interval Timer with 16-bit Pairing

This block holds two interval timer channels, each with an 8-bit up-counter and an 8-bit compare register. A channel that is running advances once per cycle in which the shared clock enable is high. When the count equals the compare value, the channel raises a one-cycle interrupt, flips its timer output and returns to zero on the same edge. The interval is therefore the compare value plus one enabled cycles. In continuous mode the channel keeps going. In one-shot mode it stops itself after the first match.

The two channels can be joined into one 16-bit timer. In that case the lower channel supplies the low byte and the upper channel counts the carries out of it. A match then requires both halves to equal their compare bytes, and only the upper channel's interrupt and output are used. Each channel can be started and stopped by writing its run bit. It can also be started and stopped by an external trigger pin, which is synchronised on chip and whose active edge is selectable. A small write port loads the compare, control and run registers. The counts, the run bits, the interrupts and the timer outputs all come out as registered ports.

Top module: `tmr_pair`

## Requirements
- R1: A synchronous active-high reset clears both counters, both run bits, both interrupts and both timer outputs to 0. It also clears all compare and control registers.
- R2: A write with `wr_en_i` high takes effect at that clock edge, with this address decode:
  - Address 0 loads the lower compare byte and address 1 loads the upper compare byte.
  - Address 2 loads the lower control nibble and address 3 loads the upper control nibble. The control bits are: bit0 one-shot, bit1 trigger enable, bit2 falling-edge trigger, bit3 pair mode.
  - Address 4 loads run bit k from data bit k.
  - Addresses 5 to 7 change nothing.
- R3: A running channel's counter rises by one on every edge where `ce_i` is high. The counter holds when `ce_i` is low or when the channel is stopped.
- R4: On an enabled edge where the count equals the compare value, the counter goes to 0. The repeat interval is therefore compare+1 enabled cycles, and compare values 0 and 255 both give a valid interval.
- R5: A match sets the channel's `irq_o` bit high for exactly the cycle in which the counter reads 0 after that match.
- R6: Each channel's `tout_o` bit inverts on each of its matches and holds otherwise.
- R7: In one-shot mode (control bit0 = 1) a channel's run bit clears at its match, so the counter stays at 0.
- R8: With trigger enable set, `trig_i` passes through two synchronising flip-flops. The active edge sets the run bit and the opposite edge clears it. The active edge is rising when control bit2 is 0 and falling when it is 1. The run bit changes at the third clock edge after the pin changes. With trigger enable clear, the pin has no effect.
- R9: When several sources act on a run bit in the same cycle, the priority from highest to lowest is: a run-bit write, then a trigger edge, then a one-shot clear.
- R10: Pair mode is active when control bit3 is set in either channel. In pair mode:
  - The lower channel's run bit and clock enable drive the pair, and its one-shot bit governs the pair.
  - The upper counter advances only when the lower counter passes from 255 to 0.
  - A match needs both counters equal to their compare bytes, and both counters then clear.
- R11: In pair mode `irq_o[0]` stays low and `tout_o[0]` holds. The upper channel's one-shot bit has no effect on its run bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_i | input | 1 | Count enable shared by both channels |
| trig_i | input | 1 | External start/stop trigger (asynchronous) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Register write data |
| cnt_o | output | 16 | Upper counter in [15:8], lower counter in [7:0] |
| run_o | output | 2 | Run bit per channel |
| irq_o | output | 2 | Match interrupt pulse per channel |
| tout_o | output | 2 | Toggling timer output per channel |

## Verification
The bench uses the default parameters: 8-bit halves and a two-stage trigger synchroniser. With 8-bit halves, the carry from 255 into the upper counter and full 16-bit match intervals of a few hundred cycles can be reached in a short run. Compare values are kept mostly small, so that in the random phase matches, one-shot stops and trigger edges fall in the same cycles as run-bit writes. The directed phases cover compare values 0 and 255, both trigger polarities, and pair mode with the upper channel's one-shot bit set.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTL_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTL_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_RUN    = 3'd4;

  // control nibble: bit3 pair, bit2 falling trigger, bit1 trigger enable, bit0 one-shot
  typedef struct packed {
    logic pair;
    logic trig_fall;
    logic trig_en;
    logic one_shot;
  } chan_ctl_t;
endpackage

// File: rtl/tmr_trig_sync.sv
module tmr_trig_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], trig_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[SYNC_STAGES-1] & prev_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pair_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int NCH   = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [CNT_W-1:0]           wr_data_i,
  output logic [NCH-1:0][CNT_W-1:0]  cmp_o,
  output chan_ctl_t [NCH-1:0]        ctl_o,
  output logic                       run_wr_o,
  output logic [NCH-1:0]             run_val_o
);
  localparam int CTL_W = $bits(chan_ctl_t);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_o <= '0;
      ctl_o <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        A_CMP_LO: cmp_o[0] <= wr_data_i;
        A_CMP_HI: cmp_o[1] <= wr_data_i;
        A_CTL_LO: ctl_o[0] <= chan_ctl_t'(wr_data_i[CTL_W-1:0]);
        A_CTL_HI: ctl_o[1] <= chan_ctl_t'(wr_data_i[CTL_W-1:0]);
        default: ;
      endcase
    end
  end

  assign run_wr_o  = wr_en_i && (wr_addr_i == A_RUN);
  assign run_val_o = wr_data_i[NCH-1:0];
endmodule

// File: rtl/tmr_run_ctl.sv
module tmr_run_ctl (
  input  logic clk,
  input  logic rst,
  input  logic sw_wr_i,
  input  logic sw_val_i,
  input  logic trig_en_i,
  input  logic act_edge_i,
  input  logic inact_edge_i,
  input  logic os_clr_i,
  output logic run_o
);
  always_ff @(posedge clk) begin
    if (rst)                             run_o <= 1'b0;
    else if (sw_wr_i)                    run_o <= sw_val_i;
    else if (trig_en_i && act_edge_i)    run_o <= 1'b1;
    else if (trig_en_i && inact_edge_i)  run_o <= 1'b0;
    else if (os_clr_i)                   run_o <= 1'b0;
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             hit_i,
  input  logic             flag_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tout_o,
  output logic             irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o  <= '0;
      tout_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= hit_i & flag_en_i;
      if (hit_i) begin
        cnt_o  <= '0;
        tout_o <= tout_o ^ flag_en_i;
      end else if (inc_i) begin
        cnt_o <= cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pair_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ce_i,
  input  logic               trig_i,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_addr_i,
  input  logic [CNT_W-1:0]   wr_data_i,
  output logic [2*CNT_W-1:0] cnt_o,
  output logic [1:0]         run_o,
  output logic [1:0]         irq_o,
  output logic [1:0]         tout_o
);
  localparam int NCH = 2;

  logic [NCH-1:0][CNT_W-1:0] cmp_q;
  chan_ctl_t [NCH-1:0]       ctl_q;
  logic                      run_wr;
  logic [NCH-1:0]            run_val;
  logic                      trig_rise, trig_fall;
  logic [NCH-1:0][CNT_W-1:0] cnt;
  logic [NCH-1:0]            tick, eq, inc, hit, flag_en, os_clr;
  logic                      pair_mode, low_wrap, pair_hit;

  tmr_regs #(.CNT_W(CNT_W), .NCH(NCH)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .cmp_o(cmp_q), .ctl_o(ctl_q),
    .run_wr_o(run_wr), .run_val_o(run_val)
  );

  tmr_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .trig_i(trig_i), .rise_o(trig_rise), .fall_o(trig_fall)
  );

  assign pair_mode = ctl_q[0].pair | ctl_q[1].pair;
  assign low_wrap  = &cnt[0];
  assign pair_hit  = tick[0] & eq[0] & eq[1];

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign tick[k] = run_o[k] & ce_i;
    assign eq[k]   = (cnt[k] == cmp_q[k]);

    if (k == 0) begin : g_low
      assign inc[k]     = tick[k];
      assign hit[k]     = pair_mode ? pair_hit : (tick[k] & eq[k]);
      assign flag_en[k] = ~pair_mode;
      assign os_clr[k]  = hit[k] & ctl_q[k].one_shot;
    end else begin : g_high
      assign inc[k]     = pair_mode ? (tick[0] & low_wrap) : tick[k];
      assign hit[k]     = pair_mode ? pair_hit : (tick[k] & eq[k]);
      assign flag_en[k] = 1'b1;
      assign os_clr[k]  = hit[k] & ctl_q[k].one_shot & ~pair_mode;
    end

    tmr_run_ctl u_run (
      .clk(clk), .rst(rst),
      .sw_wr_i(run_wr), .sw_val_i(run_val[k]),
      .trig_en_i(ctl_q[k].trig_en),
      .act_edge_i(ctl_q[k].trig_fall ? trig_fall : trig_rise),
      .inact_edge_i(ctl_q[k].trig_fall ? trig_rise : trig_fall),
      .os_clr_i(os_clr[k]),
      .run_o(run_o[k])
    );

    tmr_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst(rst), .inc_i(inc[k]), .hit_i(hit[k]),
      .flag_en_i(flag_en[k]), .cnt_o(cnt[k]), .tout_o(tout_o[k]), .irq_o(irq_o[k])
    );

    assign cnt_o[k*CNT_W +: CNT_W] = cnt[k];
  end
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
  parameter int CNT_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               ce_i,
  input logic [2*CNT_W-1:0] cnt_o,
  input logic [1:0]         run_o,
  input logic [1:0]         irq_o,
  input logic [1:0]         tout_o,
  input logic               pair_mode,
  input logic [CNT_W-1:0]   cmp_lo
);
  logic [CNT_W-1:0] cnt_lo, cnt_hi;
  assign cnt_lo = cnt_o[CNT_W-1:0];
  assign cnt_hi = cnt_o[2*CNT_W-1:CNT_W];

  p_irq_lo_zero_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o[0] |-> cnt_lo == '0);
  p_irq_hi_zero_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o[1] |-> cnt_hi == '0);
  p_tout_flip_r6: assert property (@(posedge clk) disable iff (rst)
    irq_o[1] |-> tout_o[1] != $past(tout_o[1]));
  p_pair_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (pair_mode && $past(pair_mode)) |-> (!irq_o[0] && tout_o[0] == $past(tout_o[0])));
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!run_o[0] || !ce_i) |=> $stable(cnt_lo));
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!pair_mode && run_o[0] && ce_i && cnt_lo != cmp_lo) |=> cnt_lo == $past(cnt_lo) + 1'b1);
endmodule

bind tmr_pair tmr_pair_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ce_i(ce_i), .cnt_o(cnt_o), .run_o(run_o),
  .irq_o(irq_o), .tout_o(tout_o), .pair_mode(pair_mode), .cmp_lo(cmp_q[0])
);

// File: tb/tmr_pair_tb.sv
`timescale 1ns/1ps
module tmr_pair_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ce = 1'b0, trig = 1'b0, we = 1'b0;
  logic [2:0]   wa = '0;
  logic [W-1:0] wd = '0;
  logic [2*W-1:0] cnt_o;
  logic [1:0]   run_o, irq_o, tout_o;

  int    n_chk = 0, n_fail = 0;
  bit    chk_en = 1'b0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  tmr_pair u_dut (
    .clk(clk), .rst(rst), .ce_i(ce), .trig_i(trig), .wr_en_i(we),
    .wr_addr_i(wa), .wr_data_i(wd), .cnt_o(cnt_o), .run_o(run_o),
    .irq_o(irq_o), .tout_o(tout_o)
  );

  // reference state computed from the requirements
  logic [W-1:0] m_cnt [2];
  logic [W-1:0] m_cmp [2];
  logic [3:0]   m_ctl [2];
  logic [1:0]   m_run, m_irq, m_tout;
  logic         m_s1, m_s2, m_s3;

  function automatic logic next_run(input logic cur, input logic os_clr, input logic [3:0] ctl,
                                    input logic rise, input logic fall,
                                    input logic sw, input logic sw_val);
    logic r;
    r = cur;
    if (os_clr) r = 1'b0;                                     // R7
    if (ctl[1]) begin                                         // R8
      if (ctl[2] ? fall : rise) r = 1'b1;
      else if (ctl[2] ? rise : fall) r = 1'b0;
    end
    if (sw) r = sw_val;                                       // R9: write wins
    return r;
  endfunction

  always @(posedge clk) begin : model
    logic rise, fall, pair, t0, t1, e0, e1, h0, h1, i1, sw;
    if (rst) begin
      m_cnt[0] = '0; m_cnt[1] = '0; m_cmp[0] = '0; m_cmp[1] = '0;
      m_ctl[0] = '0; m_ctl[1] = '0; m_run = '0; m_irq = '0; m_tout = '0;
      m_s1 = 1'b0; m_s2 = 1'b0; m_s3 = 1'b0;
    end else begin
      rise = m_s2 & ~m_s3;
      fall = ~m_s2 & m_s3;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = trig;
      pair = m_ctl[0][3] | m_ctl[1][3];                       // R10
      t0 = m_run[0] & ce;
      t1 = m_run[1] & ce;
      e0 = (m_cnt[0] == m_cmp[0]);
      e1 = (m_cnt[1] == m_cmp[1]);
      h0 = pair ? (t0 & e0 & e1) : (t0 & e0);
      h1 = pair ? h0 : (t1 & e1);
      i1 = pair ? (t0 & (m_cnt[0] == {W{1'b1}})) : t1;
      sw = we && (wa == 3'd4);
      m_run[0] = next_run(m_run[0], h0 & m_ctl[0][0], m_ctl[0], rise, fall, sw, wd[0]);
      m_run[1] = next_run(m_run[1], h1 & m_ctl[1][0] & ~pair, m_ctl[1], rise, fall, sw, wd[1]);
      if (h0) m_cnt[0] = '0; else if (t0) m_cnt[0] = m_cnt[0] + 1'b1;
      if (h1) m_cnt[1] = '0; else if (i1) m_cnt[1] = m_cnt[1] + 1'b1;
      m_irq[0] = h0 & ~pair;                                  // R11
      m_irq[1] = h1;
      m_tout   = m_tout ^ m_irq;                              // R6
      if (we) begin
        case (wa)
          3'd0: m_cmp[0] = wd;
          3'd1: m_cmp[1] = wd;
          3'd2: m_ctl[0] = wd[3:0];
          3'd3: m_ctl[1] = wd[3:0];
          default: ;
        endcase
      end
    end
  end

  task automatic check();
    logic [2*W-1:0] ec;
    ec = {m_cnt[1], m_cnt[0]};
    n_chk++;
    if (cnt_o !== ec || run_o !== m_run || irq_o !== m_irq || tout_o !== m_tout) begin
      n_fail++;
      $display("FAIL %s t=%0t actual cnt=%h run=%b irq=%b tout=%b expected cnt=%h run=%b irq=%b tout=%b",
               tag, $time, cnt_o, run_o, irq_o, tout_o, ec, m_run, m_irq, m_tout);
    end
  endtask

  task automatic cyc(input logic c, input logic t, input logic w, input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    if (chk_en) check();
    ce = c; trig = t; we = w; wa = a; wd = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, trig, 1'b0, 3'd0, '0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    cyc(1'b1, trig, 1'b1, a, d);
  endtask

  task automatic set_trig(input logic t, input int n);
    cyc(1'b1, t, 1'b0, 3'd0, '0);
    idle(n);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin : stim
    void'($urandom(32'd7315));
    @(posedge clk);
    chk_en = 1'b1;
    tag = "R1";                       // reset state
    repeat (3) cyc(1'b0, 1'b0, 1'b0, 3'd0, '0);
    @(negedge clk); rst = 1'b0;

    tag = "R2";                       // decode, unused addresses
    wr(3'd0, 8'd5); wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    wr(3'd4, 8'h01); idle(20);

    tag = "R3";                       // enable gating
    for (int i = 0; i < 60; i++) cyc(1'($urandom % 2), 1'b0, 1'b0, 3'd0, '0);

    tag = "R4";                       // compare extremes
    wr(3'd0, 8'd0); idle(10);
    wr(3'd0, 8'hFF); idle(600);

    tag = "R6";                       // both channels independently
    wr(3'd0, 8'd2); wr(3'd1, 8'd3); wr(3'd4, 8'h03); idle(40);

    tag = "R7";                       // one-shot
    wr(3'd4, 8'h00); wr(3'd2, 8'h01); wr(3'd0, 8'd4); wr(3'd4, 8'h01); idle(20);

    tag = "R8";                       // trigger, both polarities and disabled
    wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd0, 8'd9);
    set_trig(1'b1, 6); set_trig(1'b0, 6);
    wr(3'd2, 8'h02);
    set_trig(1'b1, 12); set_trig(1'b0, 6);
    wr(3'd2, 8'h06);
    set_trig(1'b1, 6); set_trig(1'b0, 12); set_trig(1'b1, 6);

    tag = "R9";                       // collisions of write, trigger, one-shot
    wr(3'd2, 8'h03); wr(3'd0, 8'd2);
    for (int off = 0; off < 5; off++) begin
      set_trig(~trig, off);
      wr(3'd4, 8'h00);
      idle(4);
    end

    tag = "R10";                      // 16-bit pair
    wr(3'd4, 8'h00); wr(3'd2, 8'h08); wr(3'd0, 8'd1); wr(3'd1, 8'd1);
    wr(3'd4, 8'h01); idle(600);

    tag = "R11";                      // pair with upper one-shot, then pair one-shot
    wr(3'd3, 8'h01); idle(300);
    wr(3'd2, 8'h09); wr(3'd4, 8'h01); idle(300);

    tag = "R9";                       // constrained random mix
    for (int i = 0; i < 5000; i++) begin
      logic c, t, w;
      logic [2:0] a;
      logic [W-1:0] d;
      c = ($urandom % 4) != 0;
      t = (($urandom % 10) == 0) ? ~trig : trig;
      w = ($urandom % 12) == 0;
      a = 3'($urandom % 8);
      d = 8'($urandom);
      if (a <= 3'd1) d = (($urandom % 8) == 0) ? 8'hFF : 8'($urandom % 8);
      if (a == 3'd2 || a == 3'd3) d[3] = (($urandom % 6) == 0);
      cyc(c, t, w, a, d);
    end
    idle(2);
    finish_run();
  end
endmodule